// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers sixteen internal interrupt request lines into a pending register. A request is recorded on its rising edge and stays recorded until software clears it or the processor acknowledges it. The pending bits are filtered by a sixteen-bit mask word. When the global enable is on, the lowest-numbered eligible source is taken. Taking it drops the global enable, emits a one-cycle entry pulse and presents a vector address of 32 plus the source number (octal 40 through 57). Source 0 stands for catastrophic faults and cannot be masked.

Source 7 is fed by four console buttons. Each button has its own latch, with a lamp output and separate test and reset commands that report through a Z flag and a B flag. The source-7 request rises only when the OR of the latches goes from low to high. A new console interrupt therefore needs both the pending bit and every set latch to be cleared first. The raw request input for source 7 is unused.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A request line is recorded in `pend_o[n]` on the first rising clock edge at which it is high after having been low. Holding it high records nothing further, so a bit cleared while its line stays high remains clear.
- R2: Among eligible pending sources, the one with the lowest number is taken first.
- R3: When source n is taken, `vec_o` becomes 32 + n (octal 40 + n) in the cycle where `enter_o` is high, and holds that value until the next take.
- R4: The mask word is loaded from `mask_i` when `mask_ld_i` is high. Source n (n ≥ 1) is eligible only when `mask_i[15-n]` was loaded as 1, so the most significant bit belongs to source 0's position. The mask resets to all zeros.
- R5: Source 0 is eligible whenever it is pending, whatever the mask holds.
- R6: A take happens only while `en_o` is 1 and an eligible source is pending. The clock edge that follows sets `enter_o` for exactly one cycle and clears `en_o`. The taken pending bit stays set.
- R7: `en_set_i` sets `en_o` on the next edge and `en_clr_i` clears it. After reset, `en_o`, `enter_o`, `pend_o` and `lamp_o` are all zero.
- R8: `ack_i` clears the pending bit of the most recently taken source. `clr_i[n]` clears pending bit n. A new rising edge on the same source in the same cycle keeps the bit set.
- R9: A high level on `btn_i[k]` sets console latch k, shown on `lamp_o[k]`. Source 7 is recorded when the OR of the latches rises, one cycle after the latch sets. `req_i[7]` has no effect.
- R10: `con_test_i` loads `z_o` with latch `con_sel_i` on the next edge. `con_rst_i` loads `b_o` with the value that latch held before the command and clears the latch, unless its button is still held.
- R11: Clearing `pend_o[7]` leaves the latches untouched. While any latch is still set, a further button press does not set `pend_o[7]` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Raw request lines, bit n for source n (bit 7 unused) |
| mask_ld_i | input | 1 | Load the mask word |
| mask_i | input | 16 | Mask word, bit 15-n enables source n |
| en_set_i | input | 1 | Set the global enable |
| en_clr_i | input | 1 | Clear the global enable |
| clr_i | input | 16 | Per-bit clear of the pending register |
| ack_i | input | 1 | Clear the pending bit of the last taken source |
| btn_i | input | 4 | Console button levels |
| con_sel_i | input | 2 | Console latch selector for test and reset |
| con_test_i | input | 1 | Test the selected latch into z_o |
| con_rst_i | input | 1 | Reset the selected latch, previous value into b_o |
| pend_o | output | 16 | Pending register |
| en_o | output | 1 | Global enable |
| enter_o | output | 1 | One-cycle pulse on a take |
| vec_o | output | 8 | Vector address of the last taken source |
| lamp_o | output | 4 | Console latch states |
| z_o | output | 1 | Result of the last test command |
| b_o | output | 1 | Result of the last reset command |

## Verification
The bench uses the default configuration: sixteen sources, four buttons, console on source 7 and vector base 32. At this size every source can be swept in turn. For each of sources 1 to 15, a mask holding only that source's MSB-first bit is loaded, and the take must land on exactly that source while all other lines are pending. A drain of all sources under a full mask walks the whole priority order. The console walk covers the path where the pending bit is cleared while a latch is still lit, then re-arms only after the latch is reset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // position of a source's enable bit inside the MSB-first mask word
  function automatic int mask_pos(input int src, input int nsrc);
    return nsrc - 1 - src;
  endfunction

  // vector address of a source
  function automatic int vec_of(input int base, input int src);
    return base + src;
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NSRC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] rise_o
);
  logic [NSRC-1:0] raw_q;
  logic [NSRC-1:0] pend_q;

  assign rise_o = raw_i & ~raw_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      raw_q  <= raw_i;
      pend_q <= (pend_q & ~clr_i) | rise_o;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NSRC; i++) begin : g_chk
      // R1
      rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[i] |=> pend_q[i]);
      // R1
      no_set_without_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[i] && !rise_o[i]) |=> !pend_q[i]);
    end
  endgenerate
endmodule

// File: rtl/con_latch.sv
module con_latch #(
  parameter int NBTN = 4,
  localparam int SW = (NBTN > 1) ? $clog2(NBTN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBTN-1:0] btn_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            test_i,
  input  logic            rst_cmd_i,
  output logic [NBTN-1:0] lamp_o,
  output logic            any_o,
  output logic            z_o,
  output logic            b_o
);
  logic [NBTN-1:0] lat_q;
  logic [NBTN-1:0] rst_mask;
  logic            z_q, b_q;

  assign rst_mask = rst_cmd_i ? (NBTN'(1) << sel_i) : '0;
  assign lamp_o   = lat_q;
  assign any_o    = |lat_q;
  assign z_o      = z_q;
  assign b_o      = b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
      z_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      lat_q <= (lat_q & ~rst_mask) | btn_i;
      if (test_i)    z_q <= lat_q[sel_i];
      if (rst_cmd_i) b_q <= lat_q[sel_i];
    end
  end

  // R10
  con_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmd_i && !btn_i[sel_i]) |=> !lat_q[$past(sel_i)]);
  // R10
  con_b_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_i |=> (b_q == $past(lat_q[sel_i])));
  // R9
  con_press_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|btn_i) |=> (|lat_q));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int NSRC = 16,
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] grant_o,
  output logic [IW-1:0]   idx_o,
  output logic            any_o
);
  import irqc_pkg::*;

  logic [NSRC-1:0] unmask;
  logic [NSRC-1:0] elig;

  genvar n;
  generate
    for (n = 0; n < NSRC; n++) begin : g_src
      if (n == 0) begin : g_bypass
        assign unmask[n] = 1'b1;
      end else begin : g_masked
        assign unmask[n] = mask_i[mask_pos(n, NSRC)];
      end
      if (n == 0) begin : g_top
        assign grant_o[n] = elig[n];
      end else begin : g_rest
        assign grant_o[n] = elig[n] & ~(|elig[n-1:0]);
      end
    end
  endgenerate

  assign elig  = pend_i & unmask;
  assign any_o = |elig;

  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IW'(i);
    end
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R4
  masked_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~unmask) == '0);
  // R2
  grant_matches_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> grant_o[idx_o]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC     = 16,
  parameter int NBTN     = 4,
  parameter int CON_SRC  = 7,
  parameter int VEC_BASE = 32,
  parameter int VEC_W    = 8,
  localparam int IW = $clog2(NSRC),
  localparam int SW = (NBTN > 1) ? $clog2(NBTN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             mask_ld_i,
  input  logic [NSRC-1:0]  mask_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic [NSRC-1:0]  clr_i,
  input  logic             ack_i,
  input  logic [NBTN-1:0]  btn_i,
  input  logic [SW-1:0]    con_sel_i,
  input  logic             con_test_i,
  input  logic             con_rst_i,
  output logic [NSRC-1:0]  pend_o,
  output logic             en_o,
  output logic             enter_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NBTN-1:0]  lamp_o,
  output logic             z_o,
  output logic             b_o
);
  import irqc_pkg::*;

  logic [NSRC-1:0]  raw;
  logic [NSRC-1:0]  clr_all;
  logic [NSRC-1:0]  rise;
  logic [NSRC-1:0]  mask_q;
  logic [NSRC-1:0]  grant;
  logic [IW-1:0]    pick_idx;
  logic             pick_any;
  logic             con_any;
  logic             take;
  logic             en_q, enter_q;
  logic [VEC_W-1:0] vec_q;
  logic [IW-1:0]    cur_q;

  always_comb begin
    raw          = req_i;
    raw[CON_SRC] = con_any;
  end

  assign clr_all = clr_i | (ack_i ? (NSRC'(1) << cur_q) : '0);
  assign take    = en_q & pick_any;

  con_latch #(.NBTN(NBTN)) u_con (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .sel_i(con_sel_i),
    .test_i(con_test_i), .rst_cmd_i(con_rst_i), .lamp_o(lamp_o),
    .any_o(con_any), .z_o(z_o), .b_o(b_o)
  );

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .raw_i(raw), .clr_i(clr_all),
    .pend_o(pend_o), .rise_o(rise)
  );

  prio_pick #(.NSRC(NSRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .mask_i(mask_q),
    .grant_o(grant), .idx_o(pick_idx), .any_o(pick_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      en_q    <= 1'b0;
      enter_q <= 1'b0;
      vec_q   <= '0;
      cur_q   <= '0;
    end else begin
      if (mask_ld_i) mask_q <= mask_i;
      if (take) en_q <= 1'b0;
      else if (en_set_i) en_q <= 1'b1;
      else if (en_clr_i) en_q <= 1'b0;
      enter_q <= take;
      if (take) begin
        vec_q <= VEC_W'(vec_of(VEC_BASE, int'(pick_idx)));
        cur_q <= pick_idx;
      end
    end
  end

  assign en_o    = en_q;
  assign enter_o = enter_q;
  assign vec_o   = vec_q;

  // R6
  enter_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |=> !enter_q);
  // R6
  enter_drops_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter_q |-> !en_q);
  // R5
  src0_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && pend_o[0]) |=> (enter_q && vec_q == VEC_W'(VEC_BASE)));
  // R6
  no_take_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !enter_q);
  // R1
  take_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack_i && !clr_i[pick_idx]) |=> pend_o[$past(pick_idx)]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0, mask_i = '0, clr_i = '0;
  logic        mask_ld_i = 0, en_set_i = 0, en_clr_i = 0, ack_i = 0;
  logic [3:0]  btn_i = '0;
  logic [1:0]  con_sel_i = '0;
  logic        con_test_i = 0, con_rst_i = 0;
  logic [15:0] pend_o;
  logic        en_o, enter_o, z_o, b_o;
  logic [7:0]  vec_o;
  logic [3:0]  lamp_o;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_ld_i(mask_ld_i),
    .mask_i(mask_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .clr_i(clr_i), .ack_i(ack_i), .btn_i(btn_i), .con_sel_i(con_sel_i),
    .con_test_i(con_test_i), .con_rst_i(con_rst_i), .pend_o(pend_o),
    .en_o(en_o), .enter_o(enter_o), .vec_o(vec_o), .lamp_o(lamp_o),
    .z_o(z_o), .b_o(b_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mbit(input int src);
    return 16'h8000 >> src;
  endfunction

  task automatic load_mask(input logic [15:0] m);
    mask_i = m; mask_ld_i = 1; tick(); mask_ld_i = 0;
  endtask

  task automatic clear_all();
    clr_i = '1; en_clr_i = 1; tick(); clr_i = '0; en_clr_i = 0;
  endtask

  // enable, then expect a take of source exp_src on the next edge
  task automatic take_expect(input int exp_src, input string tag);
    en_set_i = 1; tick(); en_set_i = 0;
    tick();
    check(enter_o == 1'b1, tag, enter_o, 1);
    check(vec_o == 8'(32 + exp_src), tag, vec_o, 32 + exp_src);
    check(en_o == 1'b0, "R6 enable dropped", en_o, 0);
  endtask

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1; tick();
    // R7 reset state
    check(pend_o == 0 && en_o == 0 && enter_o == 0 && lamp_o == 0,
          "R7 reset", int'(pend_o), 0);

    // R7 enable set and clear
    en_set_i = 1; tick(); en_set_i = 0;
    check(en_o == 1, "R7 set", en_o, 1);
    en_clr_i = 1; tick(); en_clr_i = 0;
    check(en_o == 0, "R7 clear", en_o, 0);

    // R9 req_i[7] ignored
    load_mask('1);
    req_i = 16'h0080; tick(); tick();
    check(pend_o[7] == 0, "R9 raw line 7 ignored", pend_o[7], 0);
    req_i = '0; tick();

    // R2 R3 drain every source in priority order under a full mask
    req_i = 16'hFFFF; tick();
    check(pend_o == 16'hFF7F, "R1 all recorded", int'(pend_o), 16'hFF7F);
    for (int k = 0; k < 16; k++) begin
      if (k == 7) continue;
      take_expect(k, "R2 R3 drain order");
      ack_i = 1; tick(); ack_i = 0;
      check(pend_o[k] == 0, "R8 ack clears", pend_o[k], 0);
    end
    // R1 line still held: nothing re-recorded
    tick();
    check(pend_o == 0, "R1 level does not re-record", int'(pend_o), 0);
    req_i = '0; tick();

    // R4 single-source MSB-first mask sweep
    for (int s = 1; s < 16; s++) begin
      if (s == 7) continue;
      load_mask(mbit(s));
      req_i = 16'hFFFE; tick();
      take_expect(s, "R4 mask position");
      req_i = '0;
      clear_all();
    end

    // R4 R6 all masked: no take while enabled
    load_mask('0);
    req_i = 16'hFFFE; tick(); req_i = '0;
    en_set_i = 1; tick(); en_set_i = 0;
    tick(); tick();
    check(enter_o == 0 && en_o == 1, "R6 masked no take", enter_o, 0);
    // R5 source 0 bypasses the mask
    req_i = 16'h0001; tick(); req_i = '0;
    tick();
    check(enter_o == 1 && vec_o == 8'd32, "R5 source 0", vec_o, 32);
    tick();
    check(enter_o == 0, "R6 one-cycle pulse", enter_o, 0);
    clear_all();

    // R8 new edge wins over clear in the same cycle
    req_i = 16'h0002; clr_i = 16'h0002; tick(); clr_i = '0;
    check(pend_o[1] == 1, "R8 edge beats clear", pend_o[1], 1);
    // R1 clear while held stays clear
    clr_i = 16'h0002; tick(); clr_i = '0; tick();
    check(pend_o[1] == 0, "R1 held line stays cleared", pend_o[1], 0);
    req_i = '0; clear_all();

    // console path
    load_mask('1);
    btn_i = 4'b0010; tick(); btn_i = '0;
    check(lamp_o == 4'b0010, "R9 lamp", lamp_o, 2);
    tick();
    check(pend_o[7] == 1, "R9 source 7 recorded", pend_o[7], 1);
    take_expect(7, "R9 console vector");
    clr_i = 16'h0080; tick(); clr_i = '0;
    check(lamp_o == 4'b0010, "R11 latch survives clear", lamp_o, 2);
    btn_i = 4'b1000; tick(); btn_i = '0; tick();
    check(pend_o[7] == 0, "R11 no re-arm while lit", pend_o[7], 0);
    con_sel_i = 2'd1; con_test_i = 1; tick(); con_test_i = 0;
    check(z_o == 1, "R10 test set", z_o, 1);
    con_sel_i = 2'd2; con_test_i = 1; tick(); con_test_i = 0;
    check(z_o == 0, "R10 test clear", z_o, 0);
    con_sel_i = 2'd1; con_rst_i = 1; tick();
    check(b_o == 1 && lamp_o == 4'b1000, "R10 reset b flag", b_o, 1);
    tick(); con_rst_i = 0;
    check(b_o == 0, "R10 reset again", b_o, 0);
    con_sel_i = 2'd3; con_rst_i = 1; tick(); con_rst_i = 0;
    check(lamp_o == 0, "R10 all dark", lamp_o, 0);
    btn_i = 4'b0001; tick(); btn_i = '0; tick();
    check(pend_o[7] == 1, "R11 re-arms after both cleared", pend_o[7], 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule